// File: doc/BRIEF.md
# Multi-Mode Eight-Output Addressable Latch

This block holds eight single-bit storage cells that drive eight low-side output switches. Each cycle a one-bit data value and a three-bit select arrive together with two active-low control lines, `clr_n` and `kill_n`. The pair of control lines puts the block into one of four modes.

In write mode the selected cell takes the data bit. In hold mode nothing changes. In steer mode the block acts as a 3-to-8 demultiplexer: the selected cell takes the data bit and every other cell is turned off. In wipe mode every cell is turned off.

All updates are registered on the rising clock edge. An asynchronous active-low reset turns all cells off. Each bit of `sink_on` is the gate state of one output switch. A 1 means that switch pulls its pin low, so the pin level is the inverse of the stored bit.

The control pins are plain level inputs with no handshake. Upstream logic must keep `kill_n` high whenever it changes `sel`, so that a half-settled select value is never written.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low, all bits of `sink_on` are 0 at once, without waiting for a clock edge.
- R2: The mode is taken from {`clr_n`,`kill_n`} as follows: 2'b10 is write, 2'b11 is hold, 2'b00 is steer and 2'b01 is wipe.
- R3: In write mode, the rising edge loads `din` into cell `sel`. Every other cell keeps its value.
- R4: In hold mode, `sink_on` keeps its value across the edge, whatever `din` and `sel` are.
- R5: In steer mode, after the edge `sink_on[sel]` equals `din` and every other bit is 0.
- R6: In wipe mode, `sink_on` is all zeros after the edge, whatever `din` and `sel` are.
- R7: A cell turned off by wipe or steer mode stays off through later hold cycles. It comes back on only when a write-mode cycle loads a 1 into it.
- R8: Select value n, read as an unsigned binary number, addresses `sink_on[n]`. Bit 0 of `sel` carries weight 1.
- R9: Input changes between rising edges do not reach `sink_on` before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Active-low clear control |
| kill_n | input | 1 | Active-low enable control |
| din | input | 1 | Data bit to store or steer |
| sel | input | 3 | Cell select |
| sink_on | output | 8 | Switch gate states; 1 means the pin is pulled low |

## Verification
The bench walks a 1 through every select value. A design with swapped or mis-weighted select bits would light the wrong output, and one that disturbed its neighbours would lose earlier bits. It sweeps `din` and `sel` during hold and wipe cycles to expose a design that lets those inputs leak through. It also checks that steer mode drops previously stored ones, which a design that merely writes the selected cell would keep. Finally, it changes the inputs half a cycle before an edge and samples `sink_on` before that edge, which would catch combinational leakage, and it pulses reset between edges to catch a synchronous reset.

// File: rtl/addr_latch8_pkg.sv
package addr_latch8_pkg;

  // Mode code is {clr_n, kill_n}
  typedef enum logic [1:0] {
    MODE_STEER = 2'b00,
    MODE_WIPE  = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } mode_e;

  // Per-cycle update plan shared by every cell
  typedef struct packed {
    logic load_sel;    // selected cell takes din
    logic zero_sel;    // selected cell forced off
    logic zero_other;  // unselected cells forced off
  } cell_ctrl_t;

  function automatic mode_e mode_of(input logic clr_n, input logic kill_n);
    return mode_e'({clr_n, kill_n});
  endfunction

endpackage

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch8_pkg::*;
(
  input  logic       clr_n,
  input  logic       kill_n,
  output cell_ctrl_t ctrl
);
  mode_e mode;

  always_comb begin
    mode = mode_of(clr_n, kill_n);
    ctrl = '0;
    unique case (mode)
      MODE_WRITE: ctrl.load_sel = 1'b1;
      MODE_HOLD:  ctrl = '0;
      MODE_STEER: begin
        ctrl.load_sel   = 1'b1;
        ctrl.zero_other = 1'b1;
      end
      MODE_WIPE: begin
        ctrl.zero_sel   = 1'b1;
        ctrl.zero_other = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/al_sel_dec.sv
module al_sel_dec #(
  parameter int N_CELLS = 8,
  localparam int SW = $clog2(N_CELLS)
) (
  input  logic [SW-1:0]      sel,
  output logic [N_CELLS-1:0] hit
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_hit
    assign hit[i] = (sel == SW'(i));
  end
endmodule

// File: rtl/al_cell.sv
module al_cell
  import addr_latch8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cell_ctrl_t ctrl,
  input  logic       hit,
  input  logic       din,
  output logic       q
);
  logic nxt;

  always_comb begin
    nxt = q;
    if (hit) begin
      if (ctrl.zero_sel)      nxt = 1'b0;
      else if (ctrl.load_sel) nxt = din;
    end else if (ctrl.zero_other) begin
      nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch8_pkg::*;
#(
  parameter int N_CELLS = 8,
  localparam int SW = $clog2(N_CELLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               kill_n,
  input  logic               din,
  input  logic [SW-1:0]      sel,
  output logic [N_CELLS-1:0] sink_on
);
  cell_ctrl_t         ctrl;
  logic [N_CELLS-1:0] hit;

  al_mode_dec u_mode (
    .clr_n  (clr_n),
    .kill_n (kill_n),
    .ctrl   (ctrl)
  );

  al_sel_dec #(.N_CELLS(N_CELLS)) u_sel (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    al_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .ctrl  (ctrl),
      .hit   (hit[i]),
      .din   (din),
      .q     (sink_on[i])
    );
  end
endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
  parameter int N_CELLS = 8,
  localparam int SW = $clog2(N_CELLS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_n,
  input logic               kill_n,
  input logic               din,
  input logic [SW-1:0]      sel,
  input logic [N_CELLS-1:0] sink_on
);
  logic [N_CELLS-1:0] one_hot_sel;
  assign one_hot_sel = {{(N_CELLS-1){1'b0}}, 1'b1} << sel;

  logic [N_CELLS-1:0] past_mask;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_mask <= '0;
    else        past_mask <= one_hot_sel;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !kill_n) |=> ((sink_on & past_mask) != 0) == $past(din)); // R3
  AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !kill_n) |=> (sink_on & ~past_mask) == ($past(sink_on) & ~past_mask)); // R3
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && kill_n) |=> $stable(sink_on)); // R4
  AST_STEER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !kill_n) |=> $onehot0(sink_on)); // R5
  AST_STEER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !kill_n) |=> sink_on == (past_mask & {N_CELLS{$past(din)}})); // R5
  AST_WIPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && kill_n) |=> sink_on == '0); // R6
endmodule

bind addr_latch8 addr_latch8_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_n   (clr_n),
  .kill_n  (kill_n),
  .din     (din),
  .sel     (sel),
  .sink_on (sink_on)
);

// File: tb/addr_latch8_bench.sv
module addr_latch8_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic       kill_n = 1'b1;
  logic       din = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] sink_on;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_latch8 u_addr_latch8 (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .kill_n  (kill_n),
    .din     (din),
    .sel     (sel),
    .sink_on (sink_on)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sink_on=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic c, input logic k, input logic d, input logic [2:0] s);
    clr_n = c; kill_n = k; din = d; sel = s;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset state", sink_on, 8'h00);
  endtask

  task automatic t_write_walk();
    logic [7:0] exp = 8'h00;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, 1'b1, 3'(i));
      exp[i] = 1'b1;
      chk("R3 R8 R2 write walk", sink_on, exp);
    end
    step(1'b1, 1'b0, 1'b0, 3'd3);
    chk("R3 write zero keeps others", sink_on, 8'hF7);
    step(1'b1, 1'b0, 1'b0, 3'd6);
    chk("R8 select weight", sink_on, 8'hB7);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b1, 1'(i & 1), 3'(7 - i));
      chk("R4 R2 hold ignores din/sel", sink_on, 8'hB7);
    end
  endtask

  task automatic t_edge_only();
    clr_n = 1'b1; kill_n = 1'b0; din = 1'b1; sel = 3'd6;
    #(CLK_PERIOD/4);
    chk("R9 no change before edge", sink_on, 8'hB7);
    @(negedge clk);
    chk("R9 change after edge", sink_on, 8'hF7);
  endtask

  task automatic t_steer();
    step(1'b0, 1'b0, 1'b1, 3'd2);
    chk("R5 R2 steer one", sink_on, 8'h04);
    step(1'b0, 1'b0, 1'b1, 3'd7);
    chk("R5 steer moves", sink_on, 8'h80);
    step(1'b0, 1'b0, 1'b0, 3'd7);
    chk("R5 steer zero", sink_on, 8'h00);
    step(1'b1, 1'b1, 1'b1, 3'd2);
    chk("R7 steer then hold", sink_on, 8'h00);
  endtask

  task automatic t_wipe();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b1, 3'(i));
    chk("R3 refill", sink_on, 8'hFF);
    step(1'b0, 1'b1, 1'b1, 3'd5);
    chk("R6 R2 wipe", sink_on, 8'h00);
    step(1'b0, 1'b1, 1'b0, 3'd0);
    chk("R6 wipe again", sink_on, 8'h00);
    step(1'b1, 1'b1, 1'b1, 3'd1);
    chk("R7 wipe then hold", sink_on, 8'h00);
    step(1'b1, 1'b0, 1'b1, 3'd1);
    chk("R7 rewrite after wipe", sink_on, 8'h02);
  endtask

  task automatic t_async_reset();
    step(1'b1, 1'b0, 1'b1, 3'd4);
    chk("R3 preset", sink_on, 8'h12);
    clr_n = 1'b1; kill_n = 1'b1;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", sink_on, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", sink_on, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_walk();
    t_hold();
    t_edge_only();
    t_steer();
    t_wipe();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: sink_on=%b expected=run end", sink_on);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule